// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block chooses how deeply the chip sleeps when the processor reports that it is waiting for an interrupt, and it drives the clock gate and power requests that put that choice into effect. Software writes a three-bit depth code while the chip runs. Writing the code has no effect of its own. The sequencer acts only when the core's wait-for-interrupt strobe arrives while a sleeping depth is selected.

There are three depths. The light nap stops only the core clock and wakes on any enabled pending interrupt. The deep sleep turns off every oscillator and the PLL, except a low-speed source that a real-time clock or display may need, and may also power down the flash. It wakes only on a pin edge whose interrupt is unmasked. The power-off depth turns the regulator off and holds the pin levels in a latch; only four backup registers keep their contents. A pin edge brings the block back from power-off and marks the cause.

When it wakes from deep sleep or power-off, the sequencer turns the clock sources back on. It waits for each enabled source to report ready, and waits out a fixed flash restart delay if the flash was off. Only then does it release the core clock, and it returns the depth code to run.

Top module: `lp_mode_seq`

## Requirements
- R1: After reset the core clock enable is 1, the oscillator enables equal `osc_cfg`, flash power-down, regulator-off and hold-enable are 0, the depth code reads 0, the power-off flag is 0 and all backup registers read 0.
- R2: A depth code written with `mode_we` is stored and readable on `mode_q` but changes no power output. A `wfi` pulse causes entry only when the stored code is 4 (nap), 2 (deep) or 1 (power-off); with any other code the block stays running.
- R3: In nap the core clock enable is 0, each oscillator enable equals its `osc_cfg` bit and flash power-down is 0.
- R4: Nap ends when some bit of `irq_pend & irq_en` is 1, and the core clock enable is 1 one cycle later. Pending interrupts that are masked are ignored.
- R5: In deep sleep only bits 2 (external low-speed crystal) and 3 (internal low-speed RC) of `osc_en` may be 1, and each only when its `osc_cfg` bit, `rtc_lcd_on` and `keep_ls` are all 1. Bits 0, 1 and 4 (fast internal RC, fast crystal, PLL) are 0. `flash_pd` equals the value `flash_off_deep` had at entry.
- R6: Deep sleep ends only on a pin edge of the polarity given by `gpio_rise` for that pin (1 = rising, 0 = falling) whose `gpio_wake_en` bit is 1. A steady level, an edge of the opposite polarity or an edge on a masked pin leaves the block asleep.
- R7: After a wake from deep sleep or power-off, `osc_en` returns to `osc_cfg` and the core clock stays gated until every source enabled in `osc_cfg` shows its `osc_rdy` bit. If the flash was off, the core clock then stays gated for a further FLASH_DLY cycles and until `flash_rdy` is 1. The core clock enable is therefore 1 two cycles after the wake edge when the flash was on, and FLASH_DLY+2 cycles after it when the flash was off.
- R8: In power-off, `reg_off`, `flash_pd` and `gpio_hold_en` are 1, all `osc_en` bits are 0, and `gpio_hold_val` holds the pin levels sampled at entry.
- R9: Power-off ends on any pin edge that matches that pin's polarity setting, whatever its wake mask. The wake runs the full flash-off restart of R7, sets `dpd_wake` and leaves the backup registers unchanged.
- R10: The depth code reads 0 once the block has left any sleeping depth.
- R11: Reset returns the block to run from any depth at the next clock edge, and clears `dpd_wake` and the backup registers.
- R12: `bk_we` writes `bk_wdata` to the backup register that `bk_sel` indexes (register i in bits [32i+31:32i] of `bk_q`), and is accepted only while running. A write while asleep is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset (reset pin) |
| mode_we | input | 1 | Depth code write strobe |
| mode_wdata | input | 3 | Depth code: 4 nap, 2 deep, 1 power-off |
| bk_we | input | 1 | Backup register write strobe |
| bk_sel | input | 2 | Backup register index |
| bk_wdata | input | 32 | Backup write data |
| wfi | input | 1 | Core wait-for-interrupt strobe |
| irq_pend | input | 32 | Pending interrupts |
| irq_en | input | 32 | Interrupt controller enable mask |
| gpio_pin | input | 16 | Pin levels |
| gpio_rise | input | 16 | Per-pin wake polarity, 1 rising, 0 falling |
| gpio_wake_en | input | 16 | Per-pin interrupt enable for deep-sleep wake |
| rtc_lcd_on | input | 1 | Real-time clock or display in use |
| keep_ls | input | 1 | Software keeps the low-speed source in deep sleep |
| osc_cfg | input | 5 | Programmed enables: fast RC, fast crystal, slow crystal, slow RC, PLL |
| flash_off_deep | input | 1 | Power the flash down in deep sleep |
| osc_rdy | input | 5 | Per-source ready |
| flash_rdy | input | 1 | Flash ready |
| core_clk_en | output | 1 | Core clock gate enable |
| osc_en | output | 5 | Source power enables |
| flash_pd | output | 1 | Flash power-down request |
| reg_off | output | 1 | Regulator-off request |
| mode_q | output | 3 | Stored depth code |
| dpd_wake | output | 1 | Last restart came from power-off |
| gpio_hold_en | output | 1 | Pin hold latch active |
| gpio_hold_val | output | 16 | Latched pin levels |
| bk_q | output | 128 | Four backup registers |

## Verification
The bench goes after the wake filters. It sends masked pending interrupts into a nap, and it sends opposite-polarity and masked edges into a deep sleep. A design that decoded the wake sources loosely would show up here as a clock that comes back early. It counts the exact cycles from the wake stimulus to the clock release with and without the flash delay. It also holds the ready inputs low, which catches a sequencer that ignores readiness or counts the delay wrong. It checks that the low-speed sources survive deep sleep only under the keep condition. Last, it checks that backup contents outlive power-off and writes made while asleep, and that reset clears them along with the power-off flag.

// File: rtl/lp_pkg.sv
package lp_pkg;
    typedef enum logic [2:0] {
        ST_RUN, ST_NAP, ST_DEEP, ST_OFF, ST_OSC_UP, ST_FLASH_UP
    } lp_state_e;

    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] SEL_RUN  = 3'd0;
    localparam logic [MODE_W-1:0] SEL_OFF  = 3'd1;
    localparam logic [MODE_W-1:0] SEL_DEEP = 3'd2;
    localparam logic [MODE_W-1:0] SEL_NAP  = 3'd4;

    localparam int OSC_N      = 5;
    localparam int OSC_HS_INT = 0;
    localparam int OSC_HS_EXT = 1;
    localparam int OSC_LS_EXT = 2;
    localparam int OSC_LS_INT = 3;
    localparam int OSC_PLL    = 4;

    localparam int BK_N   = 4;
    localparam int BK_SEL = $clog2(BK_N);

    function automatic logic [OSC_N-1:0] deep_keep(input logic [OSC_N-1:0] cfg,
                                                   input logic rtc_lcd,
                                                   input logic keep);
        logic [OSC_N-1:0] m;
        m = '0;
        if (rtc_lcd && keep) begin
            m[OSC_LS_EXT] = cfg[OSC_LS_EXT];
            m[OSC_LS_INT] = cfg[OSC_LS_INT];
        end
        return m;
    endfunction

    function automatic logic is_sleep_sel(input logic [MODE_W-1:0] s);
        return (s == SEL_NAP) || (s == SEL_DEEP) || (s == SEL_OFF);
    endfunction
endpackage

// File: rtl/lp_edge_det.sv
module lp_edge_det #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] rise_sel_i,
    output logic [W-1:0] edge_o
);
    logic [W-1:0] pin_q;
    logic         primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q    <= '0;
            primed_q <= 1'b0;
        end else begin
            pin_q    <= pin_i;
            primed_q <= 1'b1;
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_pin
        assign edge_o[g] = primed_q &&
            (rise_sel_i[g] ? (pin_i[g] & ~pin_q[g]) : (~pin_i[g] & pin_q[g]));
    end

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (|edge_o) |-> !$stable(pin_i)); // R6
endmodule

// File: rtl/lp_backup_regs.sv
module lp_backup_regs
    import lp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [BK_SEL-1:0] sel_i,
    input  logic [W-1:0]      wdata_i,
    output logic [BK_N*W-1:0] q_o
);
    for (genvar g = 0; g < BK_N; g++) begin : g_reg
        logic [W-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst)
                r_q <= '0;
            else if (we_i && (sel_i == BK_SEL'(g)))
                r_q <= wdata_i;
        end
        assign q_o[g*W +: W] = r_q;
    end

    AST_BK_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(q_o)); // R12
endmodule

// File: rtl/lp_seq_fsm.sv
module lp_seq_fsm
    import lp_pkg::*;
#(
    parameter int N_IRQ     = 32,
    parameter int N_GPIO    = 16,
    parameter int FLASH_DLY = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we_i,
    input  logic [MODE_W-1:0] mode_wdata_i,
    input  logic              wfi_i,
    input  logic [N_IRQ-1:0]  irq_pend_i,
    input  logic [N_IRQ-1:0]  irq_en_i,
    input  logic [N_GPIO-1:0] pin_i,
    input  logic [N_GPIO-1:0] edge_i,
    input  logic [N_GPIO-1:0] wake_en_i,
    input  logic              rtc_lcd_i,
    input  logic              keep_ls_i,
    input  logic [OSC_N-1:0]  osc_cfg_i,
    input  logic              flash_off_deep_i,
    input  logic [OSC_N-1:0]  osc_rdy_i,
    input  logic              flash_rdy_i,
    output logic              running_o,
    output logic              core_clk_en_o,
    output logic [OSC_N-1:0]  osc_en_o,
    output logic              flash_pd_o,
    output logic              reg_off_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              dpd_wake_o,
    output logic              hold_en_o,
    output logic [N_GPIO-1:0] hold_val_o
);
    localparam int CNT_W = $clog2(FLASH_DLY) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FLASH_DLY - 1);

    lp_state_e         st_q, st_n;
    logic [MODE_W-1:0] mode_q;
    logic              flash_off_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              dpd_q;
    logic [N_GPIO-1:0] hold_q;

    logic nap_wake, deep_wake, off_wake, osc_ok, sleeping, leaving;

    assign nap_wake  = |(irq_pend_i & irq_en_i);
    assign deep_wake = |(edge_i & wake_en_i);
    assign off_wake  = |edge_i;
    assign osc_ok    = &(osc_rdy_i | ~osc_cfg_i);
    assign sleeping  = (st_q == ST_NAP) || (st_q == ST_DEEP) || (st_q == ST_OFF);
    assign leaving   = sleeping && (st_n != st_q);

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_RUN: if (wfi_i && is_sleep_sel(mode_q)) begin
                if (mode_q == SEL_NAP)       st_n = ST_NAP;
                else if (mode_q == SEL_DEEP) st_n = ST_DEEP;
                else                         st_n = ST_OFF;
            end
            ST_NAP:      if (nap_wake)  st_n = ST_RUN;
            ST_DEEP:     if (deep_wake) st_n = ST_OSC_UP;
            ST_OFF:      if (off_wake)  st_n = ST_OSC_UP;
            ST_OSC_UP:   if (osc_ok)    st_n = flash_off_q ? ST_FLASH_UP : ST_RUN;
            ST_FLASH_UP: if (cnt_q == CNT_LAST && flash_rdy_i) st_n = ST_RUN;
            default:     st_n = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_RUN;
            mode_q      <= SEL_RUN;
            flash_off_q <= 1'b0;
            cnt_q       <= '0;
            dpd_q       <= 1'b0;
            hold_q      <= '0;
        end else begin
            st_q <= st_n;
            if (st_q == ST_RUN && mode_we_i)
                mode_q <= mode_wdata_i;
            if (leaving)
                mode_q <= SEL_RUN;
            if (st_q == ST_RUN && st_n == ST_DEEP)
                flash_off_q <= flash_off_deep_i;
            if (st_q == ST_RUN && st_n == ST_OFF) begin
                flash_off_q <= 1'b1;
                hold_q      <= pin_i;
            end
            if (st_q == ST_OFF && off_wake)
                dpd_q <= 1'b1;
            if (st_q != ST_FLASH_UP)
                cnt_q <= '0;
            else if (cnt_q != CNT_LAST)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        core_clk_en_o = (st_q == ST_RUN);
        reg_off_o     = (st_q == ST_OFF);
        flash_pd_o    = (st_q == ST_OFF) || ((st_q == ST_DEEP) && flash_off_q);
        unique case (st_q)
            ST_DEEP: osc_en_o = deep_keep(osc_cfg_i, rtc_lcd_i, keep_ls_i);
            ST_OFF:  osc_en_o = '0;
            default: osc_en_o = osc_cfg_i;
        endcase
    end

    assign running_o  = (st_q == ST_RUN);
    assign mode_o     = mode_q;
    assign dpd_wake_o = dpd_q;
    assign hold_en_o  = (st_q == ST_OFF);
    assign hold_val_o = hold_q;

    AST_ENTRY_NEEDS_WFI: assert property (@(posedge clk) disable iff (rst)
        $fell(core_clk_en_o) |-> $past(wfi_i)); // R2
    AST_NAP_WAKE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_NAP && st_q == ST_RUN) |-> $past(|(irq_pend_i & irq_en_i))); // R4
    AST_CLK_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_OSC_UP && st_q != ST_OSC_UP) |-> $past(&(osc_rdy_i | ~osc_cfg_i))); // R7
    AST_FLASH_READY: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_FLASH_UP && st_q == ST_RUN) |-> $past(flash_rdy_i)); // R7
    AST_OFF_ALL_DOWN: assert property (@(posedge clk) disable iff (rst)
        reg_off_o |-> (osc_en_o == '0) && flash_pd_o && !core_clk_en_o); // R8
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (hold_en_o && $past(hold_en_o)) |-> $stable(hold_val_o)); // R8
    AST_MODE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $rose(core_clk_en_o) |-> (mode_q == SEL_RUN)); // R10
endmodule

// File: rtl/lp_mode_seq.sv
module lp_mode_seq
    import lp_pkg::*;
#(
    parameter int N_IRQ     = 32,
    parameter int N_GPIO    = 16,
    parameter int BK_W      = 32,
    parameter int FLASH_DLY = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_we,
    input  logic [2:0]           mode_wdata,
    input  logic                 bk_we,
    input  logic [1:0]           bk_sel,
    input  logic [BK_W-1:0]      bk_wdata,
    input  logic                 wfi,
    input  logic [N_IRQ-1:0]     irq_pend,
    input  logic [N_IRQ-1:0]     irq_en,
    input  logic [N_GPIO-1:0]    gpio_pin,
    input  logic [N_GPIO-1:0]    gpio_rise,
    input  logic [N_GPIO-1:0]    gpio_wake_en,
    input  logic                 rtc_lcd_on,
    input  logic                 keep_ls,
    input  logic [4:0]           osc_cfg,
    input  logic                 flash_off_deep,
    input  logic [4:0]           osc_rdy,
    input  logic                 flash_rdy,
    output logic                 core_clk_en,
    output logic [4:0]           osc_en,
    output logic                 flash_pd,
    output logic                 reg_off,
    output logic [2:0]           mode_q,
    output logic                 dpd_wake,
    output logic                 gpio_hold_en,
    output logic [N_GPIO-1:0]    gpio_hold_val,
    output logic [4*BK_W-1:0]    bk_q
);
    logic [N_GPIO-1:0] edges;
    logic              running;

    lp_edge_det #(.W(N_GPIO)) u_edge (
        .clk(clk), .rst(rst), .pin_i(gpio_pin), .rise_sel_i(gpio_rise), .edge_o(edges)
    );

    lp_seq_fsm #(.N_IRQ(N_IRQ), .N_GPIO(N_GPIO), .FLASH_DLY(FLASH_DLY)) u_fsm (
        .clk(clk), .rst(rst),
        .mode_we_i(mode_we), .mode_wdata_i(mode_wdata), .wfi_i(wfi),
        .irq_pend_i(irq_pend), .irq_en_i(irq_en),
        .pin_i(gpio_pin), .edge_i(edges), .wake_en_i(gpio_wake_en),
        .rtc_lcd_i(rtc_lcd_on), .keep_ls_i(keep_ls), .osc_cfg_i(osc_cfg),
        .flash_off_deep_i(flash_off_deep), .osc_rdy_i(osc_rdy), .flash_rdy_i(flash_rdy),
        .running_o(running), .core_clk_en_o(core_clk_en), .osc_en_o(osc_en),
        .flash_pd_o(flash_pd), .reg_off_o(reg_off), .mode_o(mode_q),
        .dpd_wake_o(dpd_wake), .hold_en_o(gpio_hold_en), .hold_val_o(gpio_hold_val)
    );

    lp_backup_regs #(.W(BK_W)) u_bk (
        .clk(clk), .rst(rst), .we_i(bk_we && running), .sel_i(bk_sel),
        .wdata_i(bk_wdata), .q_o(bk_q)
    );
endmodule

// File: tb/tb_lp_mode_seq.sv
module tb_lp_mode_seq;
    localparam int NI = 32;
    localparam int NG = 16;
    localparam int FD = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_we = 0; logic [2:0] mode_wdata = 0;
    logic bk_we = 0; logic [1:0] bk_sel = 0; logic [31:0] bk_wdata = 0;
    logic wfi = 0;
    logic [NI-1:0] irq_pend = 0, irq_en = 0;
    logic [NG-1:0] gpio_pin = 0, gpio_rise = 0, gpio_wake_en = 0;
    logic rtc_lcd_on = 0, keep_ls = 0, flash_off_deep = 0, flash_rdy = 1;
    logic [4:0] osc_cfg = 5'b00001, osc_rdy = 5'b11111;
    logic core_clk_en, flash_pd, reg_off, dpd_wake, gpio_hold_en;
    logic [4:0] osc_en;
    logic [2:0] mode_q;
    logic [NG-1:0] gpio_hold_val;
    logic [127:0] bk_q;

    int n_chk = 0, n_bad = 0;
    logic [31:0] bk_model [4];

    always #2 clk = ~clk;

    lp_mode_seq #(.N_IRQ(NI), .N_GPIO(NG), .BK_W(32), .FLASH_DLY(FD)) dut (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .bk_we(bk_we), .bk_sel(bk_sel), .bk_wdata(bk_wdata), .wfi(wfi),
        .irq_pend(irq_pend), .irq_en(irq_en), .gpio_pin(gpio_pin),
        .gpio_rise(gpio_rise), .gpio_wake_en(gpio_wake_en),
        .rtc_lcd_on(rtc_lcd_on), .keep_ls(keep_ls), .osc_cfg(osc_cfg),
        .flash_off_deep(flash_off_deep), .osc_rdy(osc_rdy), .flash_rdy(flash_rdy),
        .core_clk_en(core_clk_en), .osc_en(osc_en), .flash_pd(flash_pd),
        .reg_off(reg_off), .mode_q(mode_q), .dpd_wake(dpd_wake),
        .gpio_hold_en(gpio_hold_en), .gpio_hold_val(gpio_hold_val), .bk_q(bk_q)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_deep_osc(input logic [4:0] c, input logic r, input logic k);
        logic [4:0] e = 5'b0;
        if (r && k) begin e[2] = c[2]; e[3] = c[3]; end
        return e;
    endfunction

    function automatic int exp_lat(input logic flash_off);
        return flash_off ? FD + 2 : 2;
    endfunction

    task automatic write_mode(input logic [2:0] m);
        mode_we = 1; mode_wdata = m;
        @(negedge clk);
        mode_we = 0;
    endtask

    task automatic pulse_wfi();
        wfi = 1;
        @(negedge clk);
        wfi = 0;
    endtask

    task automatic wait_clk(output int n);
        n = 0;
        while (!core_clk_en && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_bk(input string req);
        for (int i = 0; i < 4; i++)
            chk(req, longint'(bk_q[i*32 +: 32]), longint'(bk_model[i]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n, k, j, m;
        logic [2:0] sel;
        logic pre;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) bk_model[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 clk", core_clk_en, 1);
        chk("R1 osc", osc_en, osc_cfg);
        chk("R1 pd", {flash_pd, reg_off, gpio_hold_en, dpd_wake}, 0);
        chk("R1 mode", mode_q, 0);
        chk("R1 bk", bk_q == 128'd0, 1);

        for (int it = 0; it < 80; it++) begin
            // R12 backup write in run
            bk_sel = 2'($urandom_range(0, 3)); bk_wdata = $urandom;
            bk_we = 1; @(negedge clk); bk_we = 0;
            bk_model[bk_sel] = bk_wdata;
            check_bk("R12 write");

            osc_cfg = 5'($urandom); rtc_lcd_on = 1'($urandom); keep_ls = 1'($urandom);
            flash_off_deep = 1'($urandom);
            irq_en = $urandom | 32'h1;
            k = $urandom_range(0, NG - 1); j = (k + 1) % NG;
            gpio_rise = 16'($urandom);
            gpio_wake_en = 16'($urandom);
            gpio_wake_en[k] = 1; gpio_wake_en[j] = 0;
            m = $urandom_range(0, 4);
            sel = (m == 0) ? 3'd4 : (m == 1) ? 3'd2 : (m == 2) ? 3'd1 : (m == 3) ? 3'd0 : 3'd3;
            pre = (sel == 3'd2) ? gpio_rise[k] : ~gpio_rise[k];
            gpio_pin[k] = pre;
            repeat (2) @(negedge clk);

            write_mode(sel);
            // R2 write alone does nothing
            chk("R2 mode stored", mode_q, sel);
            chk("R2 no effect", {core_clk_en, reg_off, flash_pd}, 3'b100);
            pulse_wfi();

            if (sel == 3'd4) begin
                chk("R3 clk", core_clk_en, 0);
                chk("R3 osc", osc_en, osc_cfg);
                chk("R3 flash", flash_pd, 0);
                bk_sel = 0; bk_wdata = 32'hDEAD0000; bk_we = 1;
                irq_pend = ~irq_en;
                repeat (3) @(negedge clk);
                bk_we = 0;
                chk("R4 masked ignored", core_clk_en, 0);
                irq_pend = irq_en & (~irq_en + 1);
                wait_clk(n);
                irq_pend = 0;
                chk("R4 latency", n, 1);
                chk("R10 mode cleared", mode_q, 0);
                check_bk("R12 sleep write dropped");
            end else if (sel == 3'd2) begin
                chk("R5 osc", osc_en, exp_deep_osc(osc_cfg, rtc_lcd_on, keep_ls));
                chk("R5 flash", flash_pd, flash_off_deep);
                chk("R5 clk", core_clk_en, 0);
                gpio_pin[j] = ~gpio_pin[j]; @(negedge clk);
                gpio_pin[j] = ~gpio_pin[j]; @(negedge clk);
                gpio_pin[k] = ~pre; repeat (3) @(negedge clk);
                chk("R6 masked or wrong edge ignored", core_clk_en, 0);
                gpio_pin[k] = pre;
                wait_clk(n);
                chk("R7 latency", n, exp_lat(flash_off_deep));
                chk("R7 osc restored", osc_en, osc_cfg);
                chk("R10 mode cleared", mode_q, 0);
            end else if (sel == 3'd1) begin
                chk("R8 off", {reg_off, flash_pd, gpio_hold_en, core_clk_en}, 4'b1110);
                chk("R8 osc", osc_en, 0);
                chk("R8 hold", gpio_hold_val, gpio_pin);
                gpio_pin[k] = ~pre;
                wait_clk(n);
                chk("R9 latency", n, exp_lat(1'b1));
                chk("R9 flag", dpd_wake, 1);
                check_bk("R9 backup kept");
                chk("R10 mode cleared", mode_q, 0);
            end else begin
                repeat (2) @(negedge clk);
                chk("R2 no entry", {core_clk_en, reg_off}, 2'b10);
                write_mode(3'd0);
            end
        end

        // R7 ready hold-off
        osc_cfg = 5'b10011; osc_rdy = 5'b00000; flash_off_deep = 0;
        gpio_rise[0] = 1; gpio_wake_en[0] = 1; gpio_pin[0] = 0;
        repeat (2) @(negedge clk);
        write_mode(3'd2); pulse_wfi();
        gpio_pin[0] = 1;
        repeat (6) @(negedge clk);
        chk("R7 wait ready", core_clk_en, 0);
        chk("R7 osc on while waiting", osc_en, 5'b10011);
        osc_rdy = 5'b11111;
        wait_clk(n);
        chk("R7 release after ready", n, 1);

        // R7 flash ready held low
        flash_off_deep = 1; flash_rdy = 0; gpio_pin[0] = 0;
        repeat (2) @(negedge clk);
        write_mode(3'd2); pulse_wfi();
        gpio_pin[0] = 1;
        repeat (FD + 5) @(negedge clk);
        chk("R7 flash wait", core_clk_en, 0);
        flash_rdy = 1;
        wait_clk(n);
        chk("R7 flash release", n, 1);

        // R11 reset from power-off
        gpio_pin[0] = 0;
        repeat (2) @(negedge clk);
        write_mode(3'd1); pulse_wfi();
        chk("R11 asleep", reg_off, 1);
        rst = 1; @(negedge clk); rst = 0;
        for (int i = 0; i < 4; i++) bk_model[i] = 0;
        chk("R11 run", {core_clk_en, reg_off, gpio_hold_en}, 3'b100);
        chk("R11 flag cleared", dpd_wake, 0);
        chk("R11 mode", mode_q, 0);
        check_bk("R11 backup cleared");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule